// File: doc/BRIEF.md
# Transmit Queue Channel Request Scheduler

This block holds the configuration of sixteen circular transmit queues and turns it into transfer requests on eight DMA channels. For each queue it keeps a host-owned 8-bit write index, an 8-bit read index, an active flag and a channel number. Several queues may share one channel. A channel raises its request when it is enabled and at least one active, non-empty queue maps to it. It then names the queue it serves. When the consumer returns a one-cycle completion pulse, that queue's read index moves forward by one.

Each channel has a two-state controller. In `CH_IDLE` it runs a round-robin search over the eligible queues. The search starts just after the queue it served last. If the search finds a queue, the *grant* transition latches that queue and moves to `CH_BUSY`. In `CH_BUSY` the request is shown while the channel is enabled. A completion pulse accepted there is the *complete* transition back to `CH_IDLE`. It advances the read index and leaves the request low for exactly one cycle before the next grant. Each channel therefore has at most one frame outstanding. Because a queue maps to a single channel, each queue also has at most one frame outstanding, and frames leave in order.

The host reaches every setting through a word-addressed register port. Writes take effect on the next clock edge. Reads are combinational.

- Address `0x00` holds the channel enables.
- Address `0x01` holds the empty flags.
- Address `0x02` holds the chain selects.
- Addresses `0x10+q` hold the write indexes.
- Addresses `0x20+q` hold the read indexes.
- Addresses `0x30+q` hold the status words.

Top module: `txq_sched`

## Requirements
- R1: After reset, all channel requests are low, and every index, status word, enable, empty flag and chain select reads 0.
- R2: A status write at `0x30+q` updates status bit i (for i = 0..9) only when write-data bit 10+i is 1. The status word is laid out as follows:
  - bit 0: active
  - bits 4:1: channel number
  - bit 5: window space left
  - bit 8: acknowledged-window mode
  - Reads return bits 9:0, with bits 31:10 as 0.
- R3: A write to `0x01` updates empty flag q (data bit q) only when write-data bit 16+q is 1. Reads return the flags in bits 15:0.
- R4: The chain-select register at `0x02` stores bits 15:0. Reads return 0 in bits 31:16.
- R5: The channel-enable register at `0x00` holds one bit per channel in bits 7:0. A channel whose bit is 0 shows no request, starting in the cycle after the write.
- R6: A queue is eligible for channel c when all of the following hold:
  - it is active;
  - its channel number equals c;
  - its empty flag is 0;
  - its read index differs from its write index.
  
  One cycle after a channel in `CH_IDLE` sees an eligible queue, its request rises.
- R7: While a channel requests, its 4-bit queue output names the granted queue.
- R8: Among eligible queues on one channel, the grant goes to the first one found after the last granted queue, with wraparound. After reset the search starts at queue 0.
- R9: A completion pulse on a requesting channel does two things:
  - it advances the granted queue's read index by 1 modulo 256 (0xFF wraps to 0x00);
  - it holds the request low for exactly one cycle; the request returns in the next cycle if an eligible queue exists.
- R10: A completion pulse on a channel that is not requesting changes no read index.
- R11: A queue whose empty flag is set, or whose read index equals its write index, is not granted. The channel stays quiet until another queue becomes eligible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| chan_req | output | 8 | Transfer request, one bit per channel |
| chan_qid | output | 32 | Granted queue per channel, 4 bits each, channel c at bits 4c+3:4c |
| chan_done | input | 8 | One-cycle completion pulse, one bit per channel |

## Verification
The checks assume three things about the inputs:
- completion pulses last one cycle;
- the host does not write a queue's read index in the same cycle a completion advances it; a host write would win;
- the register address never selects a queue number beyond those that exist.

The stimulus meets these conditions. It pulses completion only between register writes, and only from a settled negative edge. It also keeps all addresses inside the documented map. Completion pulses on an idle channel are applied on purpose, to show that they are ignored.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;

    // status word layout (bits the eligibility logic decodes)
    localparam int STAT_W       = 10;
    localparam int STAT_ACT     = 0;
    localparam int STAT_CH_LSB  = 1;
    localparam int STAT_CH_W    = 4;
    localparam int STAT_MASK_LSB = 10;

    // address regions (reg_addr[7:4])
    localparam logic [3:0] RG_GLOBAL = 4'h0;
    localparam logic [3:0] RG_WPTR   = 4'h1;
    localparam logic [3:0] RG_RPTR   = 4'h2;
    localparam logic [3:0] RG_STAT   = 4'h3;

    // global registers (reg_addr[3:0] inside RG_GLOBAL)
    localparam logic [3:0] GA_CHEN  = 4'h0;
    localparam logic [3:0] GA_EMPTY = 4'h1;
    localparam logic [3:0] GA_CHAIN = 4'h2;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_BUSY = 1'b1
    } ch_state_e;

endpackage

// File: rtl/txq_sched_regs.sv
module txq_sched_regs
    import txq_sched_pkg::*;
#(
    parameter int NQ = 16,
    parameter int NC = 8,
    parameter int IW = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [7:0]                    addr_i,
    input  logic [31:0]                   wdata_i,
    input  logic [NQ-1:0]                 adv_i,
    output logic [31:0]                   rdata_o,
    output logic [NQ-1:0][IW-1:0]         wptr_o,
    output logic [NQ-1:0][IW-1:0]         rptr_o,
    output logic [NQ-1:0]                 act_o,
    output logic [NQ-1:0][STAT_CH_W-1:0]  chsel_o,
    output logic [NC-1:0]                 chen_o,
    output logic [NQ-1:0]                 empty_o
);

    logic [NQ-1:0][IW-1:0]     wptr_q;
    logic [NQ-1:0][IW-1:0]     rptr_q;
    logic [NQ-1:0][STAT_W-1:0] stat_q;
    logic [NC-1:0]             chen_q;
    logic [NQ-1:0]             empty_q;
    logic [NQ-1:0]             chain_q;

    logic [3:0] region, qsel;
    logic       wr_glob, wr_wptr, wr_rptr, wr_stat;
    logic [STAT_W-1:0] stat_msk;
    logic [NQ-1:0]     empty_msk;

    assign region    = addr_i[7:4];
    assign qsel      = addr_i[3:0];
    assign wr_glob   = we_i && (region == RG_GLOBAL);
    assign wr_wptr   = we_i && (region == RG_WPTR);
    assign wr_rptr   = we_i && (region == RG_RPTR);
    assign wr_stat   = we_i && (region == RG_STAT);
    assign stat_msk  = wdata_i[STAT_MASK_LSB +: STAT_W];
    assign empty_msk = wdata_i[16 +: NQ];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            stat_q  <= '0;
            chen_q  <= '0;
            empty_q <= '0;
            chain_q <= '0;
        end else begin
            if (wr_glob && qsel == GA_CHEN)  chen_q  <= wdata_i[NC-1:0];
            if (wr_glob && qsel == GA_EMPTY) empty_q <= (empty_q & ~empty_msk) | (wdata_i[NQ-1:0] & empty_msk);
            if (wr_glob && qsel == GA_CHAIN) chain_q <= wdata_i[NQ-1:0];
            for (int q = 0; q < NQ; q++) begin
                if (wr_wptr && qsel == 4'(q)) wptr_q[q] <= wdata_i[IW-1:0];
                if (wr_stat && qsel == 4'(q))
                    stat_q[q] <= (stat_q[q] & ~stat_msk) | (wdata_i[STAT_W-1:0] & stat_msk);
                if (wr_rptr && qsel == 4'(q)) rptr_q[q] <= wdata_i[IW-1:0];
                else if (adv_i[q])            rptr_q[q] <= rptr_q[q] + 1'b1;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (region)
            RG_GLOBAL: begin
                if (qsel == GA_CHEN)  rdata_o[NC-1:0] = chen_q;
                if (qsel == GA_EMPTY) rdata_o[NQ-1:0] = empty_q;
                if (qsel == GA_CHAIN) rdata_o[NQ-1:0] = chain_q;
            end
            RG_WPTR: rdata_o[IW-1:0]     = wptr_q[qsel];
            RG_RPTR: rdata_o[IW-1:0]     = rptr_q[qsel];
            RG_STAT: rdata_o[STAT_W-1:0] = stat_q[qsel];
            default: rdata_o = '0;
        endcase
    end

    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            act_o[q]   = stat_q[q][STAT_ACT];
            chsel_o[q] = stat_q[q][STAT_CH_LSB +: STAT_CH_W];
        end
    end

    assign wptr_o  = wptr_q;
    assign rptr_o  = rptr_q;
    assign chen_o  = chen_q;
    assign empty_o = empty_q;

    // R2: a status write with all enable bits clear leaves every status word unchanged
    a_r2_stat_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && stat_msk == '0) |=> $stable(stat_q));

    // R3: an empty-flag write with a zero mask leaves the flags unchanged
    a_r3_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_glob && qsel == GA_EMPTY && empty_msk == '0) |=> $stable(empty_q));

    generate
        for (genvar g = 0; g < NQ; g++) begin : g_adv_chk
            // R9: an accepted completion moves the read index forward by exactly one
            a_r9_adv_one: assert property (@(posedge clk) disable iff (!rst_n)
                (adv_i[g] && !(wr_rptr && qsel == 4'(g)))
                |=> rptr_q[g] == IW'($past(rptr_q[g]) + 1'b1));
        end
    endgenerate

endmodule

// File: rtl/txq_sched_chan.sv
module txq_sched_chan
    import txq_sched_pkg::*;
#(
    parameter int NQ = 16,
    localparam int QW = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [NQ-1:0] elig_i,
    input  logic          done_i,
    output logic          req_o,
    output logic [QW-1:0] qid_o,
    output logic [NQ-1:0] adv_o
);

    ch_state_e     state_q, state_d;
    logic [QW-1:0] cur_q, last_q;
    logic [QW-1:0] pick;
    logic          found;
    logic          accept;

    // round-robin search starting after the last grant
    always_comb begin
        found = 1'b0;
        pick  = last_q;
        for (int k = 1; k <= NQ; k++) begin
            if (!found && elig_i[(int'(last_q) + k) % NQ]) begin
                found = 1'b1;
                pick  = QW'((int'(last_q) + k) % NQ);
            end
        end
    end

    assign accept = (state_q == CH_BUSY) && en_i && done_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cur_q   <= '0;
            last_q  <= QW'(NQ - 1);
        end else begin
            state_q <= state_d;
            if (state_q == CH_IDLE && found) begin
                cur_q  <= pick;
                last_q <= pick;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (found)  state_d = CH_BUSY;   // grant
            CH_BUSY: if (accept) state_d = CH_IDLE;   // complete
        endcase
    end

    always_comb begin
        req_o = (state_q == CH_BUSY) && en_i;
        qid_o = cur_q;
        adv_o = accept ? (NQ'(1) << cur_q) : '0;
    end

    // R9: request low for the cycle after an accepted completion
    a_r9_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && done_i) |=> !req_o);

    // R6: a grant is only taken when some queue was eligible
    a_r6_grant_elig: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == CH_BUSY) |-> $past(|elig_i));

    // R9: at most one queue advances per completion
    a_r9_adv_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(adv_o));

endmodule

// File: rtl/txq_sched.sv
module txq_sched
    import txq_sched_pkg::*;
#(
    parameter int NQ = 16,
    parameter int NC = 8,
    parameter int IW = 8,
    localparam int QW = $clog2(NQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic [NC-1:0]    chan_req,
    output logic [NC*QW-1:0] chan_qid,
    input  logic [NC-1:0]    chan_done
);

    logic [NQ-1:0][IW-1:0]        wptr, rptr;
    logic [NQ-1:0]                act, empty_flag;
    logic [NQ-1:0][STAT_CH_W-1:0] chsel;
    logic [NC-1:0]                chen;
    logic [NC-1:0][NQ-1:0]        elig;
    logic [NC-1:0][NQ-1:0]        adv_c;
    logic [NQ-1:0]                adv;

    txq_sched_regs #(.NQ(NQ), .NC(NC), .IW(IW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .adv_i   (adv),
        .rdata_o (reg_rdata),
        .wptr_o  (wptr),
        .rptr_o  (rptr),
        .act_o   (act),
        .chsel_o (chsel),
        .chen_o  (chen),
        .empty_o (empty_flag)
    );

    always_comb begin
        for (int c = 0; c < NC; c++)
            for (int q = 0; q < NQ; q++)
                elig[c][q] = chen[c] && act[q] && (chsel[q] == STAT_CH_W'(c))
                             && !empty_flag[q] && (rptr[q] != wptr[q]);
    end

    always_comb begin
        adv = '0;
        for (int c = 0; c < NC; c++) adv = adv | adv_c[c];
    end

    generate
        for (genvar c = 0; c < NC; c++) begin : g_chan
            txq_sched_chan #(.NQ(NQ)) u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .en_i   (chen[c]),
                .elig_i (elig[c]),
                .done_i (chan_done[c]),
                .req_o  (chan_req[c]),
                .qid_o  (chan_qid[c*QW +: QW]),
                .adv_o  (adv_c[c])
            );

            // R5: no request on a disabled channel
            a_r5_req_enabled: assert property (@(posedge clk) disable iff (!rst_n)
                chan_req[c] |-> chen[c]);
        end
    endgenerate

    // R4: chain-select reads never show the reserved upper half
    a_r4_chain_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == {RG_GLOBAL, GA_CHAIN}) |-> reg_rdata[31:16] == 16'h0);

endmodule

// File: tb/txq_sched_bench.sv
`timescale 1ns/1ps
module txq_sched_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  chan_req;
    logic [31:0] chan_qid;
    logic [7:0]  chan_done = '0;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    txq_sched u_txq_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .chan_req  (chan_req),
        .chan_qid  (chan_qid),
        .chan_done (chan_done)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'h33, 32'h000F_FFFF, 32'h0000_03FF, 4'd2},  // R2 all enables
        '{8'h33, 32'h0000_0400, 32'h0000_03FE, 4'd2},  // R2 only bit 0 enabled
        '{8'h33, 32'h0000_0000, 32'h0000_03FE, 4'd2},  // R2 no enables
        '{8'h33, 32'h000F_FC00, 32'h0000_0000, 4'd2},  // R2 clear all
        '{8'h01, 32'hFFFF_AAAA, 32'h0000_AAAA, 4'd3},  // R3 full mask
        '{8'h01, 32'h000F_0005, 32'h0000_AAA5, 4'd3},  // R3 low nibble only
        '{8'h01, 32'h0000_FFFF, 32'h0000_AAA5, 4'd3},  // R3 zero mask
        '{8'h02, 32'hFFFF_1234, 32'h0000_1234, 4'd4},  // R4 upper half reads 0
        '{8'h00, 32'hFFFF_FF0F, 32'h0000_000F, 4'd5},  // R5 8-bit enable
        '{8'h13, 32'h0000_01C7, 32'h0000_00C7, 4'd6}   // R6 8-bit write index
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic done0();
        chan_done = 8'h01;
        @(posedge clk); @(negedge clk);
        chan_done = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(1, "req after reset", {24'h0, chan_req}, 32'h0);
        rd(8'h00, d); check(1, "enable after reset", d, 32'h0);
        rd(8'h25, d); check(1, "read index after reset", d, 32'h0);
        rd(8'h3F, d); check(1, "status after reset", d, 32'h0);

        // register table
        for (int i = 0; i < 10; i++) begin
            wr(VECS[i].addr, VECS[i].wd);
            rd(VECS[i].addr, d);
            check(int'(VECS[i].req), "register readback", d, VECS[i].exp);
        end
        check(5, "no req with no eligible queue", {24'h0, chan_req}, 32'h0);

        // clean up after the table
        wr(8'h01, 32'hFFFF_0000);
        wr(8'h02, 32'h0);
        wr(8'h13, 32'h0);
        wr(8'h00, 32'h01);

        // R6: inactive queue 7 on channel 1 stays quiet
        wr(8'h00, 32'h03);
        wr(8'h37, 32'h000F_FC02);        // channel 1, not active
        wr(8'h17, 32'h4);
        tick();
        check(6, "inactive queue no req", {31'h0, chan_req[1]}, 32'h0);
        wr(8'h37, 32'h0000_0401);        // set active only
        tick();
        check(6, "active queue req", {31'h0, chan_req[1]}, 32'h1);
        check(7, "ch1 queue id", {28'h0, chan_qid[7:4]}, 32'h7);
        wr(8'h00, 32'h01);               // R5 disable channel 1
        check(5, "ch1 disabled", {31'h0, chan_req[1]}, 32'h0);

        // R6/R7 queue 2 on channel 0
        wr(8'h32, 32'h000F_FC01);
        wr(8'h12, 32'h3);
        tick();
        check(6, "q2 request", {31'h0, chan_req[0]}, 32'h1);
        check(7, "q2 id", {28'h0, chan_qid[3:0]}, 32'h2);

        // R5 enable gating
        wr(8'h00, 32'h00);
        check(5, "req low when disabled", {31'h0, chan_req[0]}, 32'h0);
        done0();
        rd(8'h22, d); check(10, "done while disabled ignored", d, 32'h0);
        wr(8'h00, 32'h01);
        check(5, "req back when enabled", {31'h0, chan_req[0]}, 32'h1);

        // R9 completion and one-cycle gap
        done0();
        check(9, "gap after done", {31'h0, chan_req[0]}, 32'h0);
        rd(8'h22, d); check(9, "rptr advanced", d, 32'h1);
        tick();
        check(9, "req returns", {31'h0, chan_req[0]}, 32'h1);

        // R8 round robin with queue 5 sharing channel 0
        wr(8'h35, 32'h000F_FC01);
        wr(8'h15, 32'h1);
        done0(); tick();
        check(8, "rr picks q5", {28'h0, chan_qid[3:0]}, 32'h5);
        done0(); tick();
        check(8, "rr back to q2", {28'h0, chan_qid[3:0]}, 32'h2);
        rd(8'h25, d); check(9, "q5 rptr", d, 32'h1);

        // R11 host empty flag blocks
        wr(8'h12, 32'h6);
        wr(8'h01, 32'h0004_0004);
        done0(); tick();
        check(11, "empty flag blocks", {31'h0, chan_req[0]}, 32'h0);
        rd(8'h22, d); check(9, "q2 rptr 3", d, 32'h3);
        wr(8'h01, 32'h0004_0000);
        tick();
        check(11, "cleared flag grants", {31'h0, chan_req[0]}, 32'h1);
        done0(); tick();
        done0(); tick();
        done0(); tick();
        check(11, "rptr==wptr blocks", {31'h0, chan_req[0]}, 32'h0);

        // R10 done while idle
        done0();
        rd(8'h22, d); check(10, "idle done ignored", d, 32'h6);

        // R9 wraparound
        wr(8'h22, 32'hFF);
        wr(8'h12, 32'h00);
        tick();
        check(9, "wrap req", {31'h0, chan_req[0]}, 32'h1);
        done0();
        rd(8'h22, d); check(9, "rptr wraps to 0", d, 32'h0);
        tick();
        check(11, "empty after wrap", {31'h0, chan_req[0]}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule